// File: doc/BRIEF.md
# Four-Lane Fixed-Point Arithmetic Unit

This block is the arithmetic stage for a group of four threads that run in lock step. On every cycle in which the execute strobe is high, all four lanes apply the same operation code, each to its own pair of 32-bit operands, and register the outcome. Numbers are two's complement Q8.24 values, with 8 integer bits and 24 fraction bits. The supported operations are:

- integer add, subtract and signed compare;
- a fixed-point multiply that keeps a Q8.24 result from the full 64-bit product;
- left, logical-right and arithmetic-right shifts;
- two immediate forms built from an 8-bit immediate that is shared by all lanes.

The hardware has no divider. Software divides by multiplying with a stored reciprocal. For example, 0x000051EC is roughly 1/800 in Q8.24. The compare operation produces three per-lane flags (negative, zero, positive) for the branch logic that follows this block. The compare does not change the result registers.

Top module: `fxalu_quad`

## Requirements
- R1: When `execEn` is high at a rising edge, every lane applies `op` to its own `opA`/`opB` slice. Lane i uses bits [32*i+31:32*i]. The new result appears after that same edge. `resValid` is high for exactly the cycle that follows each edge at which `execEn` was high, and is low otherwise.
- R2: Opcode 0 (add) gives a+b and opcode 1 (subtract) gives a-b, both modulo 2^32.
- R3: Opcode 2 (compare) sets lane i's flags at `flags[3*i+2:3*i]`. Bit 2 means a<b (signed), bit 1 means a==b, and bit 0 means a>b (signed). Exactly one of these bits is set. The compare leaves the lane result unchanged.
- R4: Opcode 3 (fixed multiply) outputs bits [55:24] of the signed 64-bit product a*b. This rounds toward negative infinity and discards overflow above bit 55.
- R5: Opcode 4 shifts left and opcode 5 shifts right logically, both filling with zeros. The shift amount is b[4:0]; higher bits of b are ignored.
- R6: Opcode 6 shifts right arithmetically by b[4:0] and fills vacated bits with a[31].
- R7: Opcode 7 (upper immediate) puts `imm8` in bits [31:24] of every lane result and clears bits [23:0].
- R8: Opcode 8 (immediate) writes `imm8` sign-extended to 32 bits, copying bit 7 upward, into every lane result.
- R9: When `execEn` is low, or when `op` is 9 to 15, results and flags hold their values. Only opcode 2 changes the flags.
- R10: While `rstN` is low, all results and flags are 0 and `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| execEn | input | 1 | Execute strobe; operands and opcode are sampled when high |
| op | input | 4 | Operation code shared by all lanes |
| opA | input | 128 | First operand of each lane, 32 bits per lane |
| opB | input | 128 | Second operand of each lane, 32 bits per lane |
| imm8 | input | 8 | Immediate shared by all lanes |
| result | output | 128 | Registered result of each lane, 32 bits per lane |
| flags | output | 12 | Registered compare flags, 3 bits per lane {neg, zero, pos} |
| resValid | output | 1 | High in the cycle after an execute cycle |

## Verification
The only state in the block is the per-lane result and flag registers. A wrong decode or a faulty lane path therefore shows up at the ports in the very cycle after the execute edge: the result or flags of that lane differ from the reference model. Corruption while the unit is idle shows up as a result or flag that changes when it should not. The bench compares every lane against its model on every clock, so such a drift is reported in the first cycle it occurs. Directed cases cover the corners: wrap on add and subtract, signed-versus-unsigned ordering, multiply rounding of negative values, shift counts of 0 and 31, and sign extension of the immediate.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

  // operation codes seen on the op port
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_CMP  = 4'd2;
  localparam logic [3:0] OP_FMUL = 4'd3;
  localparam logic [3:0] OP_SLL  = 4'd4;
  localparam logic [3:0] OP_SRL  = 4'd5;
  localparam logic [3:0] OP_SRA  = 4'd6;
  localparam logic [3:0] OP_LUI  = 4'd7;
  localparam logic [3:0] OP_IMM  = 4'd8;

  typedef enum logic [2:0] {
    SEL_ADD,
    SEL_SUB,
    SEL_FMUL,
    SEL_SLL,
    SEL_SRL,
    SEL_SRA,
    SEL_LUI,
    SEL_IMM
  } resSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    ldRes;
    logic    ldFlg;
    resSel_e sel;
  } aluStrobe_t;

endpackage

// File: rtl/fxalu_ctrl.sv
module fxalu_ctrl
  import fxalu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       execEn,
  input  logic [3:0] op,
  output aluStrobe_t strobe,
  output logic       resValid
);

  always_comb begin
    strobe.ldRes = 1'b0;
    strobe.ldFlg = 1'b0;
    strobe.sel   = SEL_ADD;
    unique case (op)
      OP_ADD:  begin strobe.ldRes = execEn; strobe.sel = SEL_ADD;  end
      OP_SUB:  begin strobe.ldRes = execEn; strobe.sel = SEL_SUB;  end
      OP_CMP:  begin strobe.ldFlg = execEn;                        end
      OP_FMUL: begin strobe.ldRes = execEn; strobe.sel = SEL_FMUL; end
      OP_SLL:  begin strobe.ldRes = execEn; strobe.sel = SEL_SLL;  end
      OP_SRL:  begin strobe.ldRes = execEn; strobe.sel = SEL_SRL;  end
      OP_SRA:  begin strobe.ldRes = execEn; strobe.sel = SEL_SRA;  end
      OP_LUI:  begin strobe.ldRes = execEn; strobe.sel = SEL_LUI;  end
      OP_IMM:  begin strobe.ldRes = execEn; strobe.sel = SEL_IMM;  end
      default: begin strobe.ldRes = 1'b0;   strobe.ldFlg = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= execEn;
  end

endmodule

// File: rtl/fxalu_lane.sv
module fxalu_lane
  import fxalu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int FRAC  = 24,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] resQ,
  output logic [2:0]       flgQ
);

  localparam int PROD_W = 2 * WIDTH;
  localparam int SH_W   = $clog2(WIDTH);

  logic signed [PROD_W-1:0] aWide, bWide, prod;
  logic [WIDTH-1:0]         fmulRes, sraRes, nextRes;
  logic [SH_W-1:0]          shAmt;
  logic                     isLess, isEqual;

  assign aWide   = {{WIDTH{a[WIDTH-1]}}, a};
  assign bWide   = {{WIDTH{b[WIDTH-1]}}, b};
  assign prod    = aWide * bWide;
  assign fmulRes = WIDTH'(prod >>> FRAC);
  assign shAmt   = b[SH_W-1:0];
  assign sraRes  = $signed(a) >>> shAmt;
  assign isLess  = $signed(a) < $signed(b);
  assign isEqual = (a == b);

  always_comb begin
    unique case (strobe.sel)
      SEL_ADD:  nextRes = a + b;
      SEL_SUB:  nextRes = a - b;
      SEL_FMUL: nextRes = fmulRes;
      SEL_SLL:  nextRes = a << shAmt;
      SEL_SRL:  nextRes = a >> shAmt;
      SEL_SRA:  nextRes = sraRes;
      SEL_LUI:  nextRes = {imm, {(WIDTH-IMM_W){1'b0}}};
      SEL_IMM:  nextRes = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
      default:  nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0;
      flgQ <= '0;
    end else begin
      if (strobe.ldRes) resQ <= nextRes;
      if (strobe.ldFlg) flgQ <= {isLess, isEqual, ~isLess & ~isEqual};
    end
  end

endmodule

// File: rtl/fxalu_dpath.sv
module fxalu_dpath
  import fxalu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  parameter int FRAC  = 24,
  parameter int IMM_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  aluStrobe_t             strobe,
  input  logic [LANES*WIDTH-1:0] opA,
  input  logic [LANES*WIDTH-1:0] opB,
  input  logic [IMM_W-1:0]       imm,
  output logic [LANES*WIDTH-1:0] resAll,
  output logic [LANES*3-1:0]     flgAll
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    fxalu_lane #(.WIDTH(WIDTH), .FRAC(FRAC), .IMM_W(IMM_W)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .a      (opA[g*WIDTH +: WIDTH]),
      .b      (opB[g*WIDTH +: WIDTH]),
      .imm    (imm),
      .resQ   (resAll[g*WIDTH +: WIDTH]),
      .flgQ   (flgAll[g*3 +: 3])
    );
  end

endmodule

// File: rtl/fxalu_quad.sv
module fxalu_quad
  import fxalu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  parameter int FRAC  = 24,
  parameter int IMM_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   execEn,
  input  logic [3:0]             op,
  input  logic [LANES*WIDTH-1:0] opA,
  input  logic [LANES*WIDTH-1:0] opB,
  input  logic [IMM_W-1:0]       imm8,
  output logic [LANES*WIDTH-1:0] result,
  output logic [LANES*3-1:0]     flags,
  output logic                   resValid
);

  aluStrobe_t strobe;

  fxalu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .execEn   (execEn),
    .op       (op),
    .strobe   (strobe),
    .resValid (resValid)
  );

  fxalu_dpath #(.LANES(LANES), .WIDTH(WIDTH), .FRAC(FRAC), .IMM_W(IMM_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .imm    (imm8),
    .resAll (result),
    .flgAll (flags)
  );

endmodule

// File: rtl/fxalu_quad_chk.sv
module fxalu_quad_chk #(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  parameter int IMM_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   execEn,
  input logic [3:0]             op,
  input logic [LANES*WIDTH-1:0] opA,
  input logic [LANES*WIDTH-1:0] opB,
  input logic [IMM_W-1:0]       imm8,
  input logic [LANES*WIDTH-1:0] result,
  input logic [LANES*3-1:0]     flags,
  input logic                   resValid
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> resValid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> !resValid);
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (result == '0 && flags == '0 && !resValid));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> ($stable(result) && $stable(flags)));
  a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && op > 4'd8) |=> ($stable(result) && $stable(flags)));
  a_r9_flags_only_cmp: assert property (@(posedge clk) disable iff (!rstN)
    (op != 4'd2) |=> $stable(flags));
  a_r3_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && op == 4'd2) |=> $stable(result));

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    a_r3_one_flag: assert property (@(posedge clk) disable iff (!rstN)
      (execEn && op == 4'd2) |=> $countones(flags[g*3 +: 3]) == 1);
    a_r2_add: assert property (@(posedge clk) disable iff (!rstN)
      (execEn && op == 4'd0) |=>
        result[g*WIDTH +: WIDTH] == $past(opA[g*WIDTH +: WIDTH] + opB[g*WIDTH +: WIDTH]));
    a_r6_sra_sign: assert property (@(posedge clk) disable iff (!rstN)
      (execEn && op == 4'd6) |=>
        result[g*WIDTH + WIDTH - 1] == $past(opA[g*WIDTH + WIDTH - 1]));
    a_r7_lui_shape: assert property (@(posedge clk) disable iff (!rstN)
      (execEn && op == 4'd7) |=>
        (result[g*WIDTH +: WIDTH-IMM_W] == '0 &&
         result[g*WIDTH + WIDTH - IMM_W +: IMM_W] == $past(imm8)));
  end

endmodule

bind fxalu_quad fxalu_quad_chk #(.LANES(LANES), .WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .execEn   (execEn),
  .op       (op),
  .opA      (opA),
  .opB      (opB),
  .imm8     (imm8),
  .result   (result),
  .flags    (flags),
  .resValid (resValid)
);

// File: tb/fxalu_quad_tb.sv
module fxalu_quad_tb;

  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          execEn = 1'b0;
  logic [3:0]    op = 4'd0;
  logic [127:0]  opA = '0, opB = '0;
  logic [7:0]    imm8 = '0;
  logic [127:0]  result;
  logic [11:0]   flags;
  logic          resValid;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  fxalu_quad u_dut (
    .clk(clk), .rstN(rstN), .execEn(execEn), .op(op), .opA(opA), .opB(opB),
    .imm8(imm8), .result(result), .flags(flags), .resValid(resValid)
  );

  // reference model state
  logic [31:0] expRes [NL];
  logic [2:0]  expFlg [NL];
  logic        expValid;
  string       curTag = "R10";

  function automatic string tagOf(logic en, logic [3:0] o);
    if (!en) return "R9";
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NL; i++) begin expRes[i] = '0; expFlg[i] = '0; end
      expValid = 1'b0;
      curTag = "R10";
    end else begin
      expValid = execEn;
      curTag = tagOf(execEn, op);
      if (execEn) begin
        for (int i = 0; i < NL; i++) begin
          longint sa, sb, p;
          logic [31:0] a, b;
          int sh;
          a  = opA[i*32 +: 32];
          b  = opB[i*32 +: 32];
          sa = longint'($signed(a));
          sb = longint'($signed(b));
          sh = int'(b % 32);
          case (op)
            4'd0: expRes[i] = a + b;
            4'd1: expRes[i] = a - b;
            4'd2: expFlg[i] = (sa < sb) ? 3'b100 : (sa == sb) ? 3'b010 : 3'b001;
            4'd3: begin p = sa * sb; expRes[i] = 32'(p >>> 24); end
            4'd4: expRes[i] = a << sh;
            4'd5: expRes[i] = a >> sh;
            4'd6: expRes[i] = 32'(sa >>> sh);
            4'd7: expRes[i] = {imm8, 24'h0};
            4'd8: expRes[i] = 32'(longint'($signed(imm8)));
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!finished) begin
      check("R1", {31'd0, resValid}, {31'd0, expValid});
      for (int i = 0; i < NL; i++) begin
        check(curTag, result[i*32 +: 32], expRes[i]);
        check(curTag, {29'd0, flags[i*3 +: 3]}, {29'd0, expFlg[i]});
      end
    end
  end

  task automatic issue(input logic en, input logic [3:0] o,
                       input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [31:0] a3,
                       input logic [31:0] b0, input logic [31:0] b1,
                       input logic [31:0] b2, input logic [31:0] b3,
                       input logic [7:0] im);
    @(negedge clk);
    #1;
    execEn = en; op = o; imm8 = im;
    opA = {a3, a2, a1, a0};
    opB = {b3, b2, b1, b0};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R2 add / subtract with wrap
    issue(1, 4'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h01000000, 32'h12345678,
                   32'h00000001, 32'h00000001, 32'h00800000, 32'h87654321, 8'h00);
    issue(1, 4'd1, 32'h00000000, 32'h80000000, 32'h01000000, 32'h5,
                   32'h00000001, 32'h00000001, 32'h02000000, 32'h5, 8'h00);
    // R3 compare: lt, eq, gt, signed ordering
    issue(1, 4'd2, 32'h80000000, 32'h5, 32'h7, 32'hFFFFFFFF,
                   32'h00000001, 32'h5, 32'h3, 32'h00000000, 8'h00);
    issue(1, 4'd2, 32'h1, 32'h1, 32'hFFFFFFFE, 32'h7FFFFFFF,
                   32'h1, 32'h2, 32'hFFFFFFFF, 32'h80000000, 8'h00);
    // R4 fixed multiply: 1*1, reciprocal, negative rounding, neg*neg
    issue(1, 4'd3, 32'h01000000, 32'h64000000, 32'hFFFFFFFF, 32'hFE000000,
                   32'h01000000, 32'h000051EC, 32'h00800000, 32'hFD000000, 8'h00);
    issue(1, 4'd3, 32'h7F000000, 32'h80000000, 32'h00000001, 32'hFF800000,
                   32'h02000000, 32'h80000000, 32'h00000001, 32'h00400000, 8'h00);
    // R5 shifts, upper bits of b ignored
    issue(1, 4'd4, 32'h00000001, 32'hFFFFFFFF, 32'h80000001, 32'h12345678,
                   32'd31, 32'h00000023, 32'd0, 32'hFFFFFFE4, 8'h00);
    issue(1, 4'd5, 32'h80000000, 32'hFFFFFFFF, 32'h80000001, 32'h12345678,
                   32'd31, 32'h00000024, 32'd0, 32'd8, 8'h00);
    // R6 arithmetic shift
    issue(1, 4'd6, 32'h80000000, 32'h7FFFFFFF, 32'hF0000000, 32'hFFFFFFFF,
                   32'd31, 32'd4, 32'h00000020, 32'd17, 8'h00);
    // R7, R8 immediates
    issue(1, 4'd7, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8, 8'hA5);
    issue(1, 4'd8, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8, 8'h80);
    issue(1, 4'd8, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8, 8'h7F);
    // R9 idle and reserved codes hold
    issue(0, 4'd0, 32'hAAAA, 32'hBBBB, 32'hCCCC, 32'hDDDD, 32'h1, 32'h1, 32'h1, 32'h1, 8'h11);
    issue(0, 4'd2, 32'h0, 32'h9, 32'h0, 32'h9, 32'h9, 32'h0, 32'h9, 32'h0, 8'h11);
    issue(1, 4'd12, 32'hAAAA, 32'hBBBB, 32'hCCCC, 32'hDDDD, 32'h1, 32'h1, 32'h1, 32'h1, 8'h11);
    issue(1, 4'd15, 32'hAAAA, 32'hBBBB, 32'hCCCC, 32'hDDDD, 32'h1, 32'h1, 32'h1, 32'h1, 8'h11);
    // mixed random traffic, all lanes (R1)
    for (int k = 0; k < 400; k++) begin
      issue(($urandom % 4) != 0, 4'($urandom % 16),
            $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom, 8'($urandom));
    end
    issue(0, 4'd0, '0, '0, '0, '0, '0, '0, '0, '0, 8'h00);
    // R10 reset mid-run
    @(negedge clk); #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    #2 finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule